// File: doc/BRIEF.md
# Thirty-Two Source Interrupt Controller Core

This block gathers thirty-two asynchronous interrupt request lines into two processor-facing outputs. One is a normal interrupt line and one is a machine-check line. Each request is first resynchronised to the core clock. Software then chooses, per source, two things:

- whether the source is level-sensitive or edge-sensitive;
- which level or transition counts as active.

A latched status bit records each request. An enable register masks these bits. A routing register sends every enabled, pending source to either the normal or the critical output.

Software reaches the block through a single-cycle register bus. A write takes effect at the clock edge on which it is presented. A read returns its data on the following cycle. Status bits are cleared by writing ones. A read-only priority register gives the lowest-numbered enabled pending source, so an interrupt handler needs a single read to find what to service. Sources 17, 18 and 19 do not exist and behave as hard zeros.

Top module: `irq_router`

## Requirements
- R1: Source n is driven on `req_in[31-n]` and occupies bit 31-n of every register, so source 0 is the most significant bit.
- R2: For a level source, status is set on every cycle the synchronised input is at its active level. A write-one-clear therefore has no lasting effect while the input stays active, and clears the bit once the input is inactive.
- R3: For an edge source, status is set once per synchronised transition of the selected direction. Polarity 1 selects rising and polarity 0 selects falling. The opposite transition sets nothing, and a held level does not set the bit again after it has been cleared.
- R4: For a level source, polarity bit 1 means active high and polarity bit 0 means active low.
- R5: Writing 1 to a status bit (offset 0) clears it, and writing 0 leaves it unchanged. If a new set event and a clear of the same bit fall on the same clock edge, the bit ends up set.
- R6: The masked status register (offset 5, read-only) equals status AND enable (enable at offset 1). A pending source whose enable bit is 0 drives neither output.
- R7: A masked pending source whose route bit (offset 4) is 1 drives `irq_norm`; one whose route bit is 0 drives `irq_crit`. Timing of a request:
  - status is set on the third rising clock edge after the input changes;
  - the output rises on the fourth rising clock edge.
- R8: The priority register (offset 6, read-only) holds the number of the lowest-numbered source pending in masked status, zero-extended. It reads 32 when no source is pending.
- R9: Sources 17, 18 and 19 (bits 14, 13 and 12) read 0 in status and enable. They ignore bus writes and request activity.
- R10: After reset the registers hold these values:
  - status, enable, trigger (offset 2) and polarity (offset 3) are 0, meaning all sources are level and active low;
  - route is all ones;
  - both outputs are low.
- R11: A read (`bus_sel`=1, `bus_wr`=0) places the register selected by `bus_addr` on `bus_rdata` after the next rising edge, and the value holds until the next read. Trigger bit 1 selects edge and bit 0 selects level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| req_in | input | 32 | Asynchronous request lines, source n on bit 31-n |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_norm | output | 1 | Normal interrupt output |
| irq_crit | output | 1 | Machine-check interrupt output |

## Verification
The status update and a software write-one-clear of the same bit can coincide on one clock edge. The bench provokes this on an edge-sensitive source. It raises the request and counts cycles so that the clearing write is presented exactly on the third edge, when the synchronised edge sets the bit. The collision is judged by reading status afterwards: the bit must still be set. A second, ordinary clear must then remove it for good.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

  localparam int unsigned REG_AW = 3;

  typedef enum logic [REG_AW-1:0] {
    REG_STAT  = 3'd0,
    REG_ENAB  = 3'd1,
    REG_TRIG  = 3'd2,
    REG_POLA  = 3'd3,
    REG_ROUTE = 3'd4,
    REG_MSTAT = 3'd5,
    REG_PIDX  = 3'd6
  } reg_sel_e;

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int unsigned     W       = 32,
  parameter int unsigned     STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage_q [STAGES];

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[g] <= RST_VAL;
          else     stage_q[g] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[g] <= RST_VAL;
          else     stage_q[g] <= stage_q[g-1];
        end
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/irq_detect.sv
module irq_detect #(
  parameter int unsigned  N       = 32,
  parameter logic [N-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] lvl,
  input  logic [N-1:0] trig,
  input  logic [N-1:0] pol,
  output logic [N-1:0] set_vec
);

  logic [N-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= RST_VAL;
    else     prev_q <= lvl;
  end

  generate
    for (genvar b = 0; b < N; b++) begin : g_bit
      logic active;
      logic edge_hit;
      assign active   = pol[b] ? lvl[b] : ~lvl[b];
      assign edge_hit = pol[b] ? (lvl[b] & ~prev_q[b]) : (~lvl[b] & prev_q[b]);
      assign set_vec[b] = trig[b] ? edge_hit : active;
    end
  endgenerate

endmodule

// File: rtl/irq_prio.sv
module irq_prio #(
  parameter int unsigned N     = 32,
  parameter int unsigned IDX_W = $clog2(N + 1)
) (
  input  logic [N-1:0]     masked,
  output logic [IDX_W-1:0] idx
);

  localparam logic [IDX_W-1:0] NONE_IDX = IDX_W'(N);

  always_comb begin
    idx = NONE_IDX;
    for (int s = N - 1; s >= 0; s--) begin
      if (masked[N-1-s]) idx = IDX_W'(s);
    end
  end

endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int unsigned        NUM_SRC     = 32,
  parameter int unsigned        SYNC_STAGES = 2,
  parameter logic [NUM_SRC-1:0] RSVD_MASK   = 32'h0000_7000,
  parameter logic [NUM_SRC-1:0] IDLE_LEVEL  = '1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] req_in,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [REG_AW-1:0]  bus_addr,
  input  logic [NUM_SRC-1:0] bus_wdata,
  output logic [NUM_SRC-1:0] bus_rdata,
  output logic               irq_norm,
  output logic               irq_crit
);

  localparam int unsigned IDX_W = $clog2(NUM_SRC + 1);

  logic [NUM_SRC-1:0] status_q, enable_q, trig_q, pol_q, route_q;
  logic [NUM_SRC-1:0] lvl_sync, set_raw, set_vec, masked, clr_vec;
  logic [IDX_W-1:0]   pidx;
  logic               wr_hit, rd_hit;
  reg_sel_e           sel;

  assign sel    = reg_sel_e'(bus_addr);
  assign wr_hit = bus_sel & bus_wr;
  assign rd_hit = bus_sel & ~bus_wr;

  irq_sync #(.W(NUM_SRC), .STAGES(SYNC_STAGES), .RST_VAL(IDLE_LEVEL)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (req_in),
    .q   (lvl_sync)
  );

  irq_detect #(.N(NUM_SRC), .RST_VAL(IDLE_LEVEL)) u_detect (
    .clk     (clk),
    .rst     (rst),
    .lvl     (lvl_sync),
    .trig    (trig_q),
    .pol     (pol_q),
    .set_vec (set_raw)
  );

  assign set_vec = set_raw & ~RSVD_MASK;
  assign clr_vec = (wr_hit && sel == REG_STAT) ? bus_wdata : '0;
  assign masked  = status_q & enable_q;

  irq_prio #(.N(NUM_SRC), .IDX_W(IDX_W)) u_prio (
    .masked (masked),
    .idx    (pidx)
  );

  // status: a set event outranks a clear on the same edge
  always_ff @(posedge clk) begin
    if (rst) status_q <= '0;
    else     status_q <= ((status_q & ~clr_vec) | set_vec) & ~RSVD_MASK;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      enable_q <= '0;
      trig_q   <= '0;
      pol_q    <= '0;
      route_q  <= '1;
    end else if (wr_hit) begin
      case (sel)
        REG_ENAB:  enable_q <= bus_wdata & ~RSVD_MASK;
        REG_TRIG:  trig_q   <= bus_wdata;
        REG_POLA:  pol_q    <= bus_wdata;
        REG_ROUTE: route_q  <= bus_wdata;
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (rd_hit) begin
      case (sel)
        REG_STAT:  bus_rdata <= status_q;
        REG_ENAB:  bus_rdata <= enable_q;
        REG_TRIG:  bus_rdata <= trig_q;
        REG_POLA:  bus_rdata <= pol_q;
        REG_ROUTE: bus_rdata <= route_q;
        REG_MSTAT: bus_rdata <= masked;
        REG_PIDX:  bus_rdata <= NUM_SRC'(pidx);
        default:   bus_rdata <= '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_norm <= 1'b0;
      irq_crit <= 1'b0;
    end else begin
      irq_norm <= |(masked & route_q);
      irq_crit <= |(masked & ~route_q);
    end
  end

endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk
  import irq_router_pkg::*;
#(
  parameter int unsigned        NUM_SRC   = 32,
  parameter int unsigned        IDX_W     = 6,
  parameter logic [NUM_SRC-1:0] RSVD_MASK = 32'h0000_7000
) (
  input logic               clk,
  input logic               rst,
  input logic               bus_sel,
  input logic               bus_wr,
  input logic [REG_AW-1:0]  bus_addr,
  input logic [NUM_SRC-1:0] bus_wdata,
  input logic [NUM_SRC-1:0] status,
  input logic [NUM_SRC-1:0] enable,
  input logic [NUM_SRC-1:0] route,
  input logic [NUM_SRC-1:0] set_vec,
  input logic [IDX_W-1:0]   pidx,
  input logic               irq_norm,
  input logic               irq_crit
);

  localparam logic [IDX_W-1:0] NONE_IDX = IDX_W'(NUM_SRC);

  logic [NUM_SRC-1:0] pend;
  logic               wr_stat, wr_enab;

  assign pend    = status & enable;
  assign wr_stat = bus_sel && bus_wr && (bus_addr == REG_STAT);
  assign wr_enab = bus_sel && bus_wr && (bus_addr == REG_ENAB);

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    ((status | enable) & RSVD_MASK) == '0); // R9

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
    wr_stat |=> ((status & $past(bus_wdata & ~set_vec)) == '0)); // R5

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (|(set_vec & ~RSVD_MASK)) |=>
      ((status & $past(set_vec & ~RSVD_MASK)) == $past(set_vec & ~RSVD_MASK))); // R5

  AST_ENABLE_LOAD: assert property (@(posedge clk) disable iff (rst)
    wr_enab |=> (enable == ($past(bus_wdata) & ~RSVD_MASK))); // R11

  AST_NORM_HIGH: assert property (@(posedge clk) disable iff (rst)
    (|(pend & route)) |=> irq_norm); // R7

  AST_NORM_LOW: assert property (@(posedge clk) disable iff (rst)
    !(|(pend & route)) |=> !irq_norm); // R7

  AST_CRIT_HIGH: assert property (@(posedge clk) disable iff (rst)
    (|(pend & ~route)) |=> irq_crit); // R7

  AST_CRIT_LOW: assert property (@(posedge clk) disable iff (rst)
    !(|(pend & ~route)) |=> !irq_crit); // R7

  AST_IDX_NONE: assert property (@(posedge clk) disable iff (rst)
    (pend == '0) |-> (pidx == NONE_IDX)); // R8

  AST_IDX_VALID: assert property (@(posedge clk) disable iff (rst)
    (pidx != NONE_IDX) |-> pend[NUM_SRC-1-int'(pidx)]); // R8

endmodule

bind irq_router irq_router_chk #(
  .NUM_SRC   (NUM_SRC),
  .IDX_W     (IDX_W),
  .RSVD_MASK (RSVD_MASK)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .status    (status_q),
  .enable    (enable_q),
  .route     (route_q),
  .set_vec   (set_vec),
  .pidx      (pidx),
  .irq_norm  (irq_norm),
  .irq_crit  (irq_crit)
);

// File: tb/irq_router_tb.sv
module irq_router_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] req_in = '1;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_norm, irq_crit;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  irq_router u_dut (
    .clk       (clk),
    .rst       (rst),
    .req_in    (req_in),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_norm  (irq_norm),
    .irq_crit  (irq_crit)
  );

  localparam logic [2:0] A_STAT = 3'd0, A_ENAB = 3'd1, A_TRIG = 3'd2,
                         A_POLA = 3'd3, A_ROUTE = 3'd4, A_MSTAT = 3'd5,
                         A_PIDX = 3'd6;
  localparam logic [31:0] RSVD = 32'h0000_7000;

  function automatic logic [31:0] sb(input int n);
    return 32'h1 << (31 - n);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(A_STAT, v);  chk("R10 status", v, 32'h0);
    rd(A_ENAB, v);  chk("R10 enable", v, 32'h0);
    rd(A_TRIG, v);  chk("R10 trigger", v, 32'h0);
    rd(A_POLA, v);  chk("R10 polarity", v, 32'h0);
    rd(A_ROUTE, v); chk("R10 route", v, 32'hFFFF_FFFF);
    rd(A_PIDX, v);  chk("R8 idle index", v, 32'd32);
    chk("R10 outputs", {30'b0, irq_norm, irq_crit}, 32'h0);
  endtask

  task automatic t_reserved();
    logic [31:0] v;
    wr(A_ENAB, 32'hFFFF_FFFF);
    rd(A_ENAB, v); chk("R9 enable readback", v, ~RSVD);
    wr(A_ENAB, 32'h0);
    @(negedge clk); req_in[31-18] = 1'b0; req_in[31-17] = 1'b0;
    idle(5);
    rd(A_STAT, v); chk("R9 reserved request ignored", v, 32'h0);
    @(negedge clk); req_in = '1;
    idle(4);
  endtask

  task automatic t_level();
    logic [31:0] v;
    wr(A_ENAB, sb(3));
    @(negedge clk); req_in[31-3] = 1'b0;
    idle(3); @(negedge clk);
    chk("R7 output not before fourth edge", {31'b0, irq_norm}, 32'h0);
    @(posedge clk); @(negedge clk);
    chk("R7 normal output on fourth edge", {31'b0, irq_norm}, 32'h1);
    rd(A_STAT, v); chk("R1 source 3 at bit 28", v, sb(3));
    wr(A_STAT, 32'h0);
    rd(A_STAT, v); chk("R5 write zero keeps", v, sb(3));
    wr(A_STAT, sb(3));
    rd(A_STAT, v); chk("R2 clear while active re-sets", v, sb(3));
    @(negedge clk); req_in[31-3] = 1'b1;
    idle(4);
    wr(A_STAT, sb(3));
    rd(A_STAT, v); chk("R2 clear after inactive", v, 32'h0);
    idle(2); @(negedge clk);
    chk("R7 normal output drops", {31'b0, irq_norm}, 32'h0);
    wr(A_ENAB, 32'h0);
  endtask

  task automatic t_polarity();
    logic [31:0] v;
    @(negedge clk); req_in[31-10] = 1'b0;
    wr(A_POLA, sb(10));
    idle(4);
    wr(A_STAT, 32'hFFFF_FFFF);
    rd(A_STAT, v); chk("R4 active high quiet when low", v, 32'h0);
    @(negedge clk); req_in[31-10] = 1'b1;
    idle(4);
    rd(A_STAT, v); chk("R4 active high sets when high", v, sb(10));
    wr(A_POLA, 32'h0);
    idle(4);
    wr(A_STAT, 32'hFFFF_FFFF);
    rd(A_STAT, v); chk("R4 active low quiet when high", v, 32'h0);
  endtask

  task automatic t_edge();
    logic [31:0] v;
    wr(A_TRIG, sb(6) | sb(7));
    wr(A_POLA, sb(6));
    @(negedge clk); req_in[31-6] = 1'b0;
    idle(4);
    wr(A_STAT, 32'hFFFF_FFFF);
    rd(A_STAT, v); chk("R3 falling ignored on rising source", v, 32'h0);
    @(negedge clk); req_in[31-6] = 1'b1;
    idle(4);
    rd(A_STAT, v); chk("R3 rising edge sets", v, sb(6));
    wr(A_STAT, sb(6));
    idle(4);
    rd(A_STAT, v); chk("R3 held level does not re-set", v, 32'h0);
    @(negedge clk); req_in[31-7] = 1'b0;
    idle(4);
    rd(A_STAT, v); chk("R3 falling edge sets", v, sb(7));
    wr(A_STAT, sb(7));
    @(negedge clk); req_in[31-7] = 1'b1;
    idle(4);
    rd(A_STAT, v); chk("R3 rising ignored on falling source", v, 32'h0);
    wr(A_TRIG, 32'h0); wr(A_POLA, 32'h0);
    idle(4);
    wr(A_STAT, 32'hFFFF_FFFF);
  endtask

  task automatic t_collide();
    logic [31:0] v;
    wr(A_TRIG, sb(12));
    wr(A_POLA, sb(12));
    @(negedge clk); req_in[31-12] = 1'b0;
    idle(4);
    wr(A_STAT, 32'hFFFF_FFFF);
    @(negedge clk); req_in[31-12] = 1'b1;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = A_STAT; bus_wdata = sb(12);
    @(posedge clk); @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    rd(A_STAT, v); chk("R5 set wins over same-edge clear", v, sb(12));
    wr(A_STAT, sb(12));
    rd(A_STAT, v); chk("R5 later clear removes", v, 32'h0);
    wr(A_TRIG, 32'h0); wr(A_POLA, 32'h0);
    @(negedge clk); req_in = '1;
    idle(4);
    wr(A_STAT, 32'hFFFF_FFFF);
  endtask

  task automatic t_mask_route();
    logic [31:0] v;
    @(negedge clk); req_in[31-3] = 1'b0;
    idle(5); @(negedge clk);
    rd(A_MSTAT, v); chk("R6 masked empty when disabled", v, 32'h0);
    chk("R6 no output when disabled", {30'b0, irq_norm, irq_crit}, 32'h0);
    wr(A_ROUTE, ~sb(3));
    wr(A_ENAB, sb(3));
    idle(2); @(negedge clk);
    chk("R7 critical routing", {30'b0, irq_norm, irq_crit}, 32'h1);
    rd(A_MSTAT, v); chk("R6 masked status", v, sb(3));
    wr(A_ENAB, 32'h0);
    wr(A_ROUTE, 32'hFFFF_FFFF);
    @(negedge clk); req_in = '1;
    idle(4);
    wr(A_STAT, 32'hFFFF_FFFF);
  endtask

  task automatic t_priority();
    logic [31:0] v;
    @(negedge clk); req_in[31-5] = 1'b0; req_in[31-9] = 1'b0;
    wr(A_ENAB, sb(5) | sb(9));
    idle(4);
    rd(A_PIDX, v); chk("R8 lowest source wins", v, 32'd5);
    wr(A_ENAB, sb(9));
    rd(A_PIDX, v); chk("R8 next source", v, 32'd9);
    rd(A_MSTAT, v); chk("R6 masked follows enable", v, sb(9));
    wr(A_ENAB, 32'h0);
    rd(A_PIDX, v); chk("R8 none code", v, 32'd32);
    rd(A_STAT, v); chk("R11 status offset read", v, sb(5) | sb(9));
    @(negedge clk); req_in = '1;
    idle(4);
    wr(A_STAT, 32'hFFFF_FFFF);
  endtask

  initial begin
    idle(200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    @(negedge clk); rst = 1'b0;
    t_reset();
    t_reserved();
    t_level();
    t_polarity();
    t_edge();
    t_collide();
    t_mask_route();
    t_priority();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule